// File: doc/BRIEF.md
# Line Tone Message Transmitter

This block sends a short command message of one to eight bytes to equipment at the far end of a coaxial feed. It does this by switching a 22 kHz tone on and off. A host writes the bytes into a small register file, writes the byte count less one into a length register, and then writes the send command into a 3-bit mode register. The block then shifts each byte out, most significant bit first, and follows each byte with an odd-parity bit. Every bit becomes a tone burst of fixed shape. The timing comes from a slot tick that the surrounding chip supplies, one pulse every 0.5 ms.

The output `toneOut` is a tone envelope. When it is high, the downstream line driver places the 22 kHz carrier on the line. Outside a transmission, the mode register sets the idle line: mode 1 keeps the tone on continuously, and every other value leaves the line silent. After the last bit, the block holds the line silent and stays busy for a guard interval of about 5 ms. Another transmitter can then answer on the same line. The message registers keep their contents, so the host can repeat a command with a single mode write.

Top module: `tone_msg_tx`

## Requirements
- R1: While reset is held and just after it is released, `busy`, `done` and `toneOut` are 0, and the mode register is 0.
- R2: Writes use `wrAddr` 0 to 7 for message bytes 0 to 7, address 8 for the length, and address 9 for the mode. The length takes `wrData[2:0]` as the byte count minus one. The mode takes `wrData[2:0]`, and the upper data bits are ignored.
- R3: Writing mode value 4 while not busy starts a transmission, and `busy` is 1 from the next cycle.
- R4: Bytes go out in index order from byte 0 up to byte length. Each byte is sent as its 8 data bits, MSB first, followed by one parity bit that makes the number of ones in those 9 bits odd.
- R5: Each bit takes three slots, and each slot ends on a `tickEn` pulse. The first slot starts in the cycle after the start write. A 0 bit is sent as tone, tone, silence. A 1 bit is sent as tone, silence, silence.
- R6: After the last bit's third slot, `toneOut` stays 0 and `busy` stays 1 for GUARD_TICKS further ticks (10 by default, about 5 ms).
- R7: `done` is high for exactly one cycle. That cycle is the first cycle in which `busy` is 0 after a transmission.
- R8: While not busy, `toneOut` is 1 when the mode register holds 1 and 0 for any other mode value.
- R9: While busy, writes to the message and length registers are ignored, and a further mode-4 write does not restart or change the transmission in progress.
- R10: The message and length registers keep their values after a transmission, so another mode-4 write resends the same waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle slot tick, nominally every 0.5 ms |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register address (0-7 message, 8 length, 9 mode) |
| wrData | input | 8 | Register write data |
| busy | output | 1 | Transmission or guard interval in progress |
| done | output | 1 | One-cycle pulse when the guard interval ends |
| toneOut | output | 1 | Tone envelope: 1 = 22 kHz carrier on |

## Verification
Each slot's tone level is fixed by the state in the cycle that carries its closing tick. The bench therefore samples `toneOut` on the falling edge of each cycle in which `tickEn` is high. It compares that sample with the slot computed from the byte model. `busy` is due one cycle after the start write, so it is checked at the next falling edge. Each idle tone level is likewise checked one cycle after its mode write. `done` and the fall of `busy` come one cycle after the final guard tick. The bench checks them at the falling edge that follows the last guard sample, and checks one cycle later that `done` has cleared.

// File: rtl/tone_msg_pkg.sv
package tone_msg_pkg;

  localparam int MODE_W        = 3;
  localparam int SLOTS_PER_BIT = 3;
  localparam logic [MODE_W-1:0] MODE_SEND = 3'd4;
  localparam logic [MODE_W-1:0] MODE_TONE = 3'd1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_GUARD
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadByte;
    logic       shiftBit;
    logic       sending;
    logic       busy;
    logic [1:0] slot;
  } dpCtl_t;

endpackage

// File: rtl/tone_msg_dp.sv
module tone_msg_dp
  import tone_msg_pkg::*;
#(
  parameter int MSG_BYTES = 8,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4,
  localparam int LEN_W    = $clog2(MSG_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  dpCtl_t            ctl,
  input  logic [LEN_W-1:0]  byteSel,
  output logic              startReq,
  output logic [LEN_W-1:0]  lenQ,
  output logic              toneOut
);

  localparam int FRAME_W = DATA_W + 1;
  localparam logic [ADDR_W-1:0] LEN_ADDR  = ADDR_W'(MSG_BYTES);
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(MSG_BYTES + 1);

  logic [DATA_W-1:0]  msgQ [MSG_BYTES];
  logic [MODE_W-1:0]  modeQ;
  logic [FRAME_W-1:0] shiftQ;
  logic               curBit;
  logic               burstOn;

  // message storage, one register per byte
  for (genvar g = 0; g < MSG_BYTES; g++) begin : gMsg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        msgQ[g] <= '0;
      else if (wrEn && !ctl.busy && wrAddr == ADDR_W'(g))
        msgQ[g] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      lenQ <= '0;
    else if (wrEn && !ctl.busy && wrAddr == LEN_ADDR)
      lenQ <= wrData[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      modeQ <= '0;
    else if (wrEn && wrAddr == MODE_ADDR)
      modeQ <= wrData[MODE_W-1:0];
  end

  assign startReq = wrEn && !ctl.busy && wrAddr == MODE_ADDR &&
                    wrData[MODE_W-1:0] == MODE_SEND;

  // byte plus odd parity, shifted out MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      shiftQ <= '0;
    else if (ctl.loadByte)
      shiftQ <= {msgQ[byteSel], ~^msgQ[byteSel]};
    else if (ctl.shiftBit)
      shiftQ <= {shiftQ[FRAME_W-2:0], 1'b0};
  end

  assign curBit = shiftQ[FRAME_W-1];

  // slot 0 always tone, slot 1 tone only for a zero, slot 2 silent
  always_comb begin
    unique case (ctl.slot)
      2'd0:    burstOn = 1'b1;
      2'd1:    burstOn = !curBit;
      default: burstOn = 1'b0;
    endcase
  end

  assign toneOut = ctl.sending ? burstOn : (!ctl.busy && modeQ == MODE_TONE);

endmodule

// File: rtl/tone_msg_ctrl.sv
module tone_msg_ctrl
  import tone_msg_pkg::*;
#(
  parameter int MSG_BYTES   = 8,
  parameter int DATA_W      = 8,
  parameter int GUARD_TICKS = 10,
  localparam int LEN_W      = $clog2(MSG_BYTES),
  localparam int FRAME_W    = DATA_W + 1,
  localparam int BIT_W      = $clog2(FRAME_W),
  localparam int GUARD_W    = $clog2(GUARD_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             startReq,
  input  logic [LEN_W-1:0] lenQ,
  output dpCtl_t           ctl,
  output logic [LEN_W-1:0] byteSel,
  output logic             busy,
  output logic             done
);

  txState_t           stateQ;
  logic [1:0]         slotQ;
  logic [BIT_W-1:0]   bitQ;
  logic [LEN_W-1:0]   byteQ;
  logic [GUARD_W-1:0] guardQ;
  logic               bitEnd;
  logic               frameEnd;
  logic               msgEnd;

  assign bitEnd   = stateQ == ST_SEND && tickEn && slotQ == 2'(SLOTS_PER_BIT - 1);
  assign frameEnd = bitEnd && bitQ == BIT_W'(FRAME_W - 1);
  assign msgEnd   = frameEnd && byteQ == lenQ;

  always_comb begin
    ctl          = '0;
    ctl.busy     = stateQ != ST_IDLE;
    ctl.sending  = stateQ == ST_SEND;
    ctl.slot     = slotQ;
    ctl.loadByte = (stateQ == ST_IDLE && startReq) || (frameEnd && !msgEnd);
    ctl.shiftBit = bitEnd && !frameEnd;
    byteSel      = (stateQ == ST_IDLE) ? '0 : byteQ + 1'b1;
  end

  assign busy = ctl.busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      slotQ  <= '0;
      bitQ   <= '0;
      byteQ  <= '0;
      guardQ <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (stateQ)
        ST_IDLE: begin
          if (startReq) begin
            stateQ <= ST_SEND;
            slotQ  <= '0;
            bitQ   <= '0;
            byteQ  <= '0;
          end
        end
        ST_SEND: begin
          if (tickEn) begin
            if (!bitEnd) begin
              slotQ <= slotQ + 1'b1;
            end else begin
              slotQ <= '0;
              if (!frameEnd) begin
                bitQ <= bitQ + 1'b1;
              end else begin
                bitQ <= '0;
                if (msgEnd) begin
                  stateQ <= ST_GUARD;
                  guardQ <= '0;
                end else begin
                  byteQ <= byteQ + 1'b1;
                end
              end
            end
          end
        end
        ST_GUARD: begin
          if (tickEn) begin
            if (guardQ == GUARD_W'(GUARD_TICKS - 1)) begin
              stateQ <= ST_IDLE;
              done   <= 1'b1;
            end else begin
              guardQ <= guardQ + 1'b1;
            end
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tone_msg_tx.sv
module tone_msg_tx
  import tone_msg_pkg::*;
#(
  parameter int MSG_BYTES   = 8,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int GUARD_TICKS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              busy,
  output logic              done,
  output logic              toneOut
);

  localparam int LEN_W = $clog2(MSG_BYTES);

  dpCtl_t           ctl;
  logic [LEN_W-1:0] byteSel;
  logic [LEN_W-1:0] lenQ;
  logic             startReq;

  tone_msg_ctrl #(
    .MSG_BYTES  (MSG_BYTES),
    .DATA_W     (DATA_W),
    .GUARD_TICKS(GUARD_TICKS)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .startReq(startReq),
    .lenQ    (lenQ),
    .ctl     (ctl),
    .byteSel (byteSel),
    .busy    (busy),
    .done    (done)
  );

  tone_msg_dp #(
    .MSG_BYTES(MSG_BYTES),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .ctl     (ctl),
    .byteSel (byteSel),
    .startReq(startReq),
    .lenQ    (lenQ),
    .toneOut (toneOut)
  );

endmodule

// File: rtl/tone_msg_chk.sv
module tone_msg_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 3,
  parameter int MODE_A = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              busy,
  input logic              done,
  input logic              toneOut,
  input logic [LEN_W-1:0]  lenQ
);

  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrEn && wrAddr == ADDR_W'(MODE_A) && wrData[2:0] == 3'd4));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  done_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(busy));

  // R5
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$past(tickEn)) |-> $stable(toneOut));

  // R9
  len_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(lenQ));

endmodule

bind tone_msg_tx tone_msg_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .LEN_W (LEN_W),
  .MODE_A(MSG_BYTES + 1)
) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .tickEn (tickEn),
  .wrEn   (wrEn),
  .wrAddr (wrAddr),
  .wrData (wrData),
  .busy   (busy),
  .done   (done),
  .toneOut(toneOut),
  .lenQ   (lenQ)
);

// File: tb/tone_msg_tx_tb_top.sv
module tone_msg_tx_tb_top;

  localparam int GUARD   = 10;
  localparam int SLOTS_B = 27;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       busy, done, toneOut;

  int checks = 0;
  int failures = 0;
  int tickDiv = 0;
  logic [7:0] model [8];
  int modelLen = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tickDiv <= (tickDiv == 2) ? 0 : tickDiv + 1;
    tickEn  <= (tickDiv == 2);
  end

  tone_msg_tx dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .busy(busy), .done(done), .toneOut(toneOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic expSlot(input int idx);
    int b = idx / SLOTS_B;
    int r = idx % SLOTS_B;
    int bitN = r / 3;
    int slot = r % 3;
    logic [8:0] frame = {model[b], ~^model[b]};
    logic bv = frame[8 - bitN];
    if (slot == 0) return 1'b1;
    if (slot == 1) return !bv;
    return 1'b0;
  endfunction

  task automatic loadMsg(input int len, input bit randomData, input logic [7:0] fill);
    for (int i = 0; i < 8; i++) begin
      model[i] = randomData ? 8'($urandom) : fill;
      wr(4'(i), model[i]);
    end
    modelLen = len;
    // R2: only the low 3 bits form the length
    wr(4'd8, {5'($urandom), 3'(len)});
  endtask

  task automatic runMsg(input bit disturb, input string tag);
    int nSlots = (modelLen + 1) * SLOTS_B;
    int idx = 0;
    int cyc = 0;
    int badIdx = -1;
    bit guardOk = 1'b1;
    logic badAct = 1'b0;
    wr(4'd9, 8'h04);
    check(busy === 1'b1, {"R3 busy after start ", tag}, busy, 1);
    while (idx < nSlots + GUARD) begin
      if (disturb) begin
        case (cyc)
          10: begin wrEn = 1'b1; wrAddr = 4'd9; wrData = 8'h04; end
          11: begin wrAddr = 4'd0; wrData = ~model[0]; end
          12: begin wrAddr = 4'd8; wrData = 8'h00; end
          13: wrEn = 1'b0;
          default: ;
        endcase
      end
      if (tickEn) begin
        if (idx < nSlots) begin
          if (toneOut !== expSlot(idx) && badIdx < 0) begin
            badIdx = idx; badAct = toneOut;
          end
        end else if (toneOut !== 1'b0 || busy !== 1'b1) begin
          guardOk = 1'b0;
        end
        idx++;
      end
      cyc++;
      @(negedge clk);
    end
    check(badIdx < 0, {"R4 R5 waveform ", tag}, badAct, (badIdx < 0) ? 0 : int'(expSlot(badIdx)));
    check(guardOk, {"R6 guard silent and busy ", tag}, guardOk, 1);
    check(done === 1'b1 && busy === 1'b0, {"R7 done at busy fall ", tag}, {done, busy}, 2);
    @(negedge clk);
    check(done === 1'b0, {"R7 done single cycle ", tag}, done, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1
    check(busy === 1'b0, "R1 busy in reset", busy, 0);
    check(done === 1'b0, "R1 done in reset", done, 0);
    check(toneOut === 1'b0, "R1 tone in reset", toneOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && toneOut === 1'b0, "R1 after release", {busy, toneOut}, 0);

    // directed corners: one byte of zeros, one byte of ones, full eight bytes
    loadMsg(0, 1'b0, 8'h00); runMsg(1'b0, "len0 zeros");
    loadMsg(0, 1'b0, 8'hFF); runMsg(1'b0, "len0 ones");
    loadMsg(7, 1'b1, 8'h00); runMsg(1'b0, "len7 random");

    // R10: resend without reload
    runMsg(1'b0, "R10 repeat");

    // R9: writes during busy ignored, then R10 check data persisted
    loadMsg(2, 1'b1, 8'h00); runMsg(1'b1, "R9 disturbed");
    runMsg(1'b0, "R9 R10 after disturb");

    // R8 idle tone by mode, upper data bits ignored (R2)
    wr(4'd9, 8'h01); check(toneOut === 1'b1, "R8 mode 1 tone", toneOut, 1);
    wr(4'd9, 8'h00); check(toneOut === 1'b0, "R8 mode 0 silent", toneOut, 0);
    wr(4'd9, 8'hF9); check(toneOut === 1'b1, "R2 R8 mode upper bits", toneOut, 1);
    wr(4'd9, 8'h03); check(toneOut === 1'b0, "R8 mode 3 silent", toneOut, 0);
    check(busy === 1'b0, "R3 non-send modes do not start", busy, 0);

    // constrained random messages
    for (int n = 0; n < 5; n++) begin
      loadMsg(int'($urandom_range(0, 7)), 1'b1, 8'h00);
      runMsg(1'b0, "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule